// File: doc/BRIEF.md
# Cartridge Program Bank Mapper

This block is the program-side memory controller of a console cartridge. It watches the CPU bus and turns writes in the upper half of the address space into a small set of bank registers. From these registers it forms the upper program ROM address bits, A18 down to A14, for two 16 KB CPU windows. The lower window at $8000-$BFFF can be switched. The upper window at $C000-$FFFF has A17:14 pinned high. Program ROM A13:0 are wired straight from CPU A13:0 on the board and do not pass through this block.

The top program ROM bit is unusual. It does not come from the CPU address. Four one-bit registers hold candidate values, and the video bus address lines A11:10 choose which of them drives A18. As a result, A18 in the fixed upper window also follows video fetches.

The block also drives the program ROM output enable, an active-low select for the work RAM at $6000-$7FFF, and the nametable address line VRAM A10, which the mirroring register controls. All inputs are sampled on a fast system clock. PHI2 is one of those inputs, and a register write commits when PHI2 is seen to fall. Every output is registered.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, every bank register is zero. With PHI2 low and ROMSEL# high, `prg_oe_n` and `wram_cs_n` read 1 and `vram_a10` follows video A10.
- R2: A register write commits on the first clock in which PHI2 is seen low after being high. The write uses the offset and data captured during the high phase, and only when R/W was 0 and ROMSEL# was 0 in that phase. Any other bus cycle changes no register.
- R3: Only CPU A3:0 pick the register offset. The 16-offset group is therefore reached at every CPU address from $8000 to $FFFF, whatever the value of A14:13.
- R4: Offsets 0, 1, 2 and 3 each store data bit 0. The value `prg_a18_14[4]` (ROM A18) is the register whose offset equals {video A11, video A10}.
- R5: When CPU A14 is 0, `prg_a18_14[3:0]` (ROM A17:14) equals data bits 3:0 last written to offset 8.
- R6: When CPU A14 is 1, `prg_a18_14[3:0]` is 4'b1111. `prg_a18_14[4]` still follows the video-selected offset 0-3 register.
- R7: Writes to offsets 4-7 and 10-15 ($A-$F) change no output.
- R8: `prg_oe_n` is 0 exactly when ROMSEL# is 0 and R/W is 1.
- R9: `wram_cs_n` is 0 exactly when PHI2 is 1, ROMSEL# is 1 and CPU A14:13 are 2'b11.
- R10: Data bits 1:0 of offset 9 set `vram_a10`: 0 gives video A10, 1 gives video A11, 2 gives constant 0 and 3 gives constant 1.
- R11: Each output reflects its inputs as sampled at a clock edge and changes at that edge. It holds its previous value until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than PHI2 |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | CPU phase-2 clock, sampled as data |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| romsel_n | input | 1 | Active-low decode of CPU $8000-$FFFF |
| cpu_a14_13 | input | 2 | CPU address bits 14:13 |
| cpu_a3_0 | input | 4 | CPU address bits 3:0, the register offset |
| cpu_d | input | 4 | CPU data bits 3:0 |
| vid_a11_10 | input | 2 | Video bus address bits 11:10 |
| prg_a18_14 | output | 5 | Program ROM address bits 18:14 |
| prg_oe_n | output | 1 | Program ROM output enable, active low |
| wram_cs_n | output | 1 | Work RAM select for $6000-$7FFF, active low |
| vram_a10 | output | 1 | Nametable address bit 10 |

## Verification
A wrong A18 register shows up only when video A11:10 selects that register. For this reason every read check sweeps all four video values in both CPU windows. A corrupted switchable bank or mirroring register is visible on `prg_a18_14` or `vram_a10` one clock after the read inputs settle. A write that lands on the wrong offset, or that should have been ignored, changes an output that the next sweep compares against the bench's own register model. The bench also samples just before and just after the output edge, so an output that gains or loses a register stage is exposed.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int OFS_W = 4;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mir_mode_e;

  localparam logic [OFS_W-1:0] OFS_PRG_BANK = 4'h8;
  localparam logic [OFS_W-1:0] OFS_MIRROR   = 4'h9;
  localparam logic [OFS_W-1:0] OFS_SPARE_E  = 4'hE;
  localparam logic [OFS_W-1:0] OFS_SPARE_F  = 4'hF;
endpackage

// File: rtl/prg_bus_capture.sv
module prg_bus_capture #(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic              cpu_rw,
  input  logic              romsel_n,
  input  logic [OFS_W-1:0]  cpu_ofs,
  input  logic [DATA_W-1:0] cpu_d,
  output logic              wr_en,
  output logic [OFS_W-1:0]  wr_ofs,
  output logic [DATA_W-1:0] wr_data
);
  logic phi2_q;
  logic sel_q;

  // Capture the bus while PHI2 is high; commit on its fall.
  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q  <= 1'b0;
      sel_q   <= 1'b0;
      wr_ofs  <= '0;
      wr_data <= '0;
    end else begin
      phi2_q <= phi2;
      if (phi2) begin
        sel_q   <= ~cpu_rw & ~romsel_n;
        wr_ofs  <= cpu_ofs;
        wr_data <= cpu_d;
      end
    end
  end

  assign wr_en = phi2_q & ~phi2 & sel_q;

  // R2
  wr_from_write_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(!cpu_rw && !romsel_n && phi2));
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_map_pkg::*;
#(
  parameter int OFS_W     = 4,
  parameter int DATA_W    = 4,
  parameter int BANK_W    = 4,
  parameter int VID_SEL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [OFS_W-1:0]          wr_ofs,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [(1<<VID_SEL_W)-1:0] hi_bits,
  output logic [BANK_W-1:0]         prg_bank,
  output mir_mode_e                 mir_mode
);
  localparam int HI_SLOTS = 1 << VID_SEL_W;

  for (genvar s = 0; s < HI_SLOTS; s++) begin : g_hi
    always_ff @(posedge clk) begin
      if (rst)
        hi_bits[s] <= 1'b0;
      else if (wr_en && wr_ofs == OFS_W'(s))
        hi_bits[s] <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank <= '0;
      mir_mode <= MIR_VERT;
    end else if (wr_en) begin
      if (wr_ofs == OFS_PRG_BANK) prg_bank <= wr_data[BANK_W-1:0];
      if (wr_ofs == OFS_MIRROR)   mir_mode <= mir_mode_e'(wr_data[1:0]);
    end
  end

  // R2
  hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |->
      ($stable(hi_bits) && $stable(prg_bank) && $stable(mir_mode)));

  // R7
  spare_offsets_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) &&
     ($past(wr_ofs) == OFS_SPARE_E || $past(wr_ofs) == OFS_SPARE_F)) |->
      ($stable(hi_bits) && $stable(prg_bank) && $stable(mir_mode)));
endmodule

// File: rtl/prg_addr_former.sv
module prg_addr_former
  import prg_map_pkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int VID_SEL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      phi2,
  input  logic                      cpu_rw,
  input  logic                      romsel_n,
  input  logic [1:0]                cpu_a14_13,
  input  logic [VID_SEL_W-1:0]      vid_sel,
  input  logic [(1<<VID_SEL_W)-1:0] hi_bits,
  input  logic [BANK_W-1:0]         prg_bank,
  input  mir_mode_e                 mir_mode,
  output logic [BANK_W:0]           prg_hi,
  output logic                      prg_oe_n,
  output logic                      wram_cs_n,
  output logic                      vram_a10
);
  logic              top_bit;
  logic [BANK_W-1:0] low_bank;
  logic              nt_bit;

  always_comb begin
    top_bit  = hi_bits[vid_sel];
    low_bank = cpu_a14_13[1] ? {BANK_W{1'b1}} : prg_bank;
    unique case (mir_mode)
      MIR_VERT:   nt_bit = vid_sel[0];
      MIR_HORZ:   nt_bit = vid_sel[VID_SEL_W-1];
      MIR_ONE_LO: nt_bit = 1'b0;
      default:    nt_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_hi    <= '0;
      prg_oe_n  <= 1'b1;
      wram_cs_n <= 1'b1;
      vram_a10  <= 1'b0;
    end else begin
      prg_hi    <= {top_bit, low_bank};
      prg_oe_n  <= ~(~romsel_n & cpu_rw);
      wram_cs_n <= ~(phi2 & romsel_n & (&cpu_a14_13));
      vram_a10  <= nt_bit;
    end
  end

  // R6
  upper_window_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_a14_13[1])) |-> (prg_hi[BANK_W-1:0] == {BANK_W{1'b1}}));

  // R8
  oe_only_on_rom_read_chk: assert property (@(posedge clk) disable iff (rst)
    !prg_oe_n |-> $past(!romsel_n && cpu_rw));

  // R9
  wram_only_outside_rom_chk: assert property (@(posedge clk) disable iff (rst)
    !wram_cs_n |-> $past(romsel_n && phi2));

  // R10
  single_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mir_mode == MIR_ONE_HI)) |-> vram_a10);

  // R10
  vertical_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mir_mode == MIR_VERT)) |-> (vram_a10 == $past(vid_sel[0])));
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int DATA_W    = 4,
  parameter int BANK_W    = 4,
  parameter int VID_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phi2,
  input  logic                 cpu_rw,
  input  logic                 romsel_n,
  input  logic [1:0]           cpu_a14_13,
  input  logic [OFS_W-1:0]     cpu_a3_0,
  input  logic [DATA_W-1:0]    cpu_d,
  input  logic [VID_SEL_W-1:0] vid_a11_10,
  output logic [BANK_W:0]      prg_a18_14,
  output logic                 prg_oe_n,
  output logic                 wram_cs_n,
  output logic                 vram_a10
);
  localparam int HI_SLOTS = 1 << VID_SEL_W;

  logic                wr_en;
  logic [OFS_W-1:0]    wr_ofs;
  logic [DATA_W-1:0]   wr_data;
  logic [HI_SLOTS-1:0] hi_bits;
  logic [BANK_W-1:0]   prg_bank;
  mir_mode_e           mir_mode;

  prg_bus_capture #(.OFS_W(OFS_W), .DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst(rst), .phi2(phi2), .cpu_rw(cpu_rw), .romsel_n(romsel_n),
    .cpu_ofs(cpu_a3_0), .cpu_d(cpu_d),
    .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data)
  );

  prg_bank_regs #(.OFS_W(OFS_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
                  .VID_SEL_W(VID_SEL_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .hi_bits(hi_bits), .prg_bank(prg_bank), .mir_mode(mir_mode)
  );

  prg_addr_former #(.BANK_W(BANK_W), .VID_SEL_W(VID_SEL_W)) form_i (
    .clk(clk), .rst(rst), .phi2(phi2), .cpu_rw(cpu_rw), .romsel_n(romsel_n),
    .cpu_a14_13(cpu_a14_13), .vid_sel(vid_a11_10),
    .hi_bits(hi_bits), .prg_bank(prg_bank), .mir_mode(mir_mode),
    .prg_hi(prg_a18_14), .prg_oe_n(prg_oe_n), .wram_cs_n(wram_cs_n),
    .vram_a10(vram_a10)
  );
endmodule

// File: tb/prg_bank_mapper_tb.sv
`timescale 1ns/1ps
module prg_bank_mapper_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phi2 = 1'b0, cpu_rw = 1'b1, romsel_n = 1'b1;
  logic [1:0] cpu_a14_13 = '0;
  logic [3:0] cpu_a3_0 = '0, cpu_d = '0;
  logic [1:0] vid_a11_10 = '0;
  logic [4:0] prg_a18_14;
  logic       prg_oe_n, wram_cs_n, vram_a10;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [3:0] m_hi;
  logic [3:0] m_bank;
  logic [1:0] m_mir;

  always #4 clk = ~clk;

  prg_bank_mapper dut_i (
    .clk(clk), .rst(rst), .phi2(phi2), .cpu_rw(cpu_rw), .romsel_n(romsel_n),
    .cpu_a14_13(cpu_a14_13), .cpu_a3_0(cpu_a3_0), .cpu_d(cpu_d),
    .vid_a11_10(vid_a11_10), .prg_a18_14(prg_a18_14), .prg_oe_n(prg_oe_n),
    .wram_cs_n(wram_cs_n), .vram_a10(vram_a10)
  );

  function automatic logic [4:0] exp_hi(input logic upper, input logic [1:0] vid);
    return {m_hi[vid], upper ? 4'hF : m_bank};
  endfunction

  function automatic logic exp_nt(input logic [1:0] vid);
    case (m_mir)
      2'd0: return vid[0];
      2'd1: return vid[1];
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] ofs, input logic [3:0] d,
                           input logic rw, input logic rs, input logic [1:0] a);
    @(negedge clk);
    phi2 = 1'b1; cpu_rw = rw; romsel_n = rs; cpu_a14_13 = a; cpu_a3_0 = ofs; cpu_d = d;
    @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    cpu_rw = 1'b1; romsel_n = 1'b1;
    @(negedge clk);
    if (!rw && !rs) begin
      if (ofs < 4)      m_hi[ofs[1:0]] = d[0];
      else if (ofs == 8) m_bank = d;
      else if (ofs == 9) m_mir = d[1:0];
    end
  endtask

  task automatic read_check(input logic upper, input logic [1:0] vid);
    @(negedge clk);
    phi2 = 1'b1; romsel_n = 1'b0; cpu_rw = 1'b1;
    cpu_a14_13 = {upper, 1'($urandom)}; vid_a11_10 = vid;
    settle();
    chk(upper ? "R6 rom hi" : "R4/R5 rom hi", 8'(prg_a18_14), 8'(exp_hi(upper, vid)));
    chk("R10 vram_a10", 8'(vram_a10), 8'(exp_nt(vid)));
    chk("R8 oe on read", 8'(prg_oe_n), 8'h0);
  endtask

  task automatic sweep();
    for (int w = 0; w < 2; w++)
      for (int v = 0; v < 4; v++)
        read_check(w[0], v[1:0]);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_hi = '0; m_bank = '0; m_mir = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    settle();
    // R1 reset state
    chk("R1 oe idle", 8'(prg_oe_n), 8'h1);
    chk("R1 wram idle", 8'(wram_cs_n), 8'h1);
    chk("R1 vram_a10", 8'(vram_a10), 8'h0);
    read_check(1'b0, 2'd3);

    // R3 mirror: offset 8 reached with A14:13 = 01
    bus_write(4'h8, 4'h5, 1'b0, 1'b0, 2'b01);
    read_check(1'b0, 2'd0);
    // R4 distinct A18 per video slot
    bus_write(4'h1, 4'h1, 1'b0, 1'b0, 2'b10);
    bus_write(4'h2, 4'hF, 1'b0, 1'b0, 2'b11);
    sweep();
    // R2 bad cycles: read with ROMSEL# low, write with ROMSEL# high
    bus_write(4'h8, 4'hA, 1'b1, 1'b0, 2'b00);
    bus_write(4'h0, 4'h1, 1'b0, 1'b1, 2'b00);
    read_check(1'b0, 2'd0);
    // R7 spare offsets
    bus_write(4'hE, 4'hF, 1'b0, 1'b0, 2'b00);
    bus_write(4'hF, 4'hF, 1'b0, 1'b0, 2'b00);
    bus_write(4'h5, 4'hF, 1'b0, 1'b0, 2'b00);
    sweep();
    // R10 each mirroring mode
    for (int m = 0; m < 4; m++) begin
      bus_write(4'h9, 4'(m), 1'b0, 1'b0, 2'b00);
      for (int v = 0; v < 4; v++) read_check(1'b0, v[1:0]);
    end
    // R8 / R9 decode
    @(negedge clk); phi2 = 1'b1; romsel_n = 1'b1; cpu_a14_13 = 2'b11; settle();
    chk("R9 wram select", 8'(wram_cs_n), 8'h0);
    chk("R8 oe off outside rom", 8'(prg_oe_n), 8'h1);
    @(negedge clk); cpu_a14_13 = 2'b10; settle();
    chk("R9 wram other range", 8'(wram_cs_n), 8'h1);
    @(negedge clk); cpu_a14_13 = 2'b11; phi2 = 1'b0; settle();
    chk("R9 wram phi2 low", 8'(wram_cs_n), 8'h1);
    @(negedge clk); phi2 = 1'b1; romsel_n = 1'b0; cpu_rw = 1'b0; settle();
    chk("R8 oe off on write", 8'(prg_oe_n), 8'h1);
    @(negedge clk); cpu_rw = 1'b1; romsel_n = 1'b1; settle();

    // R11 output changes at the edge, not before
    bus_write(4'h9, 4'h0, 1'b0, 1'b0, 2'b00);
    @(negedge clk); vid_a11_10 = 2'b00; settle();
    @(negedge clk); vid_a11_10 = 2'b01;
    #2 chk("R11 before edge", 8'(vram_a10), 8'h0);
    @(posedge clk); #1 chk("R11 after edge", 8'(vram_a10), 8'h1);

    // Random mix
    for (int i = 0; i < 200; i++) begin
      bus_write(4'($urandom), 4'($urandom), ($urandom % 4) == 0,
                ($urandom % 4) == 0, 2'($urandom));
      if (i % 8 == 7) sweep();
      else read_check(1'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule